// File: doc/BRIEF.md
# Change-Availability Checker

This block judges, note by note, whether a vendor selling a five-unit item can always hand back exact change. Each customer pays with a single note worth 5, 10 or 20 units. The block holds a count of the 5-unit and 10-unit notes it has taken in, decides for every arriving note whether the right change can be returned from those holdings, and updates the counts to match. A single shortage spoils the whole sequence. The verdict is sticky until the host starts a new sequence.

Notes arrive on a valid/ready stream with a 2-bit note code. The block never applies back-pressure: `note_ready_o` is tied high, so every cycle with `note_valid_i` high transfers one note, and notes are consumed strictly in arrival order. A plain start/clear strobe empties the holdings and clears the verdict. A plain end-of-sequence strobe asks for the verdict. One cycle later `done_o` pulses for one cycle, and `ok_o` gives the result and keeps it until the next request.

Top module: `change_ledger`

## Requirements
- R1: `note_ready_o` is always 1. After reset or a clear strobe, both held-note counts are zero and no shortage is recorded, so a 10-unit note (code 2'b10) as the first note of a sequence causes a failure.
- R2: A note with code 2'b01 (5 units) needs no change and adds one to the 5-note count.
- R3: A note with code 2'b10 (10 units) is settled only if at least one 5-note is held. The 5 count then drops by one and the 10 count rises by one. Otherwise a shortage is recorded.
- R4: A note with code 2'b11 (20 units) is settled first with one 10-note plus one 5-note whenever both counts are nonzero, even if three 5-notes are also held.
- R5: If that pair is not available, a 20-unit note is settled with three 5-notes when at least three are held. Otherwise a shortage is recorded. Sequence 5,5,5,20 passes and 5,5,20 fails.
- R6: Code 2'b00 is not a legal note. It is skipped and changes neither count.
- R7: Once a shortage is recorded, it stays recorded and all further notes are ignored until the next clear strobe.
- R8: A `seq_end_i` pulse yields `done_o` high for exactly the next cycle, with `ok_o` = 1 only if no shortage occurred. This includes any note accepted in the same cycle as the strobe. `ok_o` holds its value between requests. Sequences 5,5,5,10,20 pass; 5,5,10,10,20 and 5,5,5,10,5,5,10,20,20,20 fail.
- R9: The 5 and 10 counts are CNT_W bits wide (default 8). They saturate at their maximum (255) instead of wrapping.
- R10: `clear_i` takes priority over a note or an end strobe in the same cycle. Both are then ignored, and the block starts a fresh empty sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Start/clear strobe: empty holdings, clear shortage |
| note_valid_i | input | 1 | A note is offered this cycle |
| note_code_i | input | 2 | 01 = 5, 10 = 10, 11 = 20, 00 = skip |
| note_ready_o | output | 1 | Always 1; no back-pressure |
| seq_end_i | input | 1 | End-of-sequence strobe requesting the verdict |
| done_o | output | 1 | One-cycle pulse after the end strobe |
| ok_o | output | 1 | Verdict: 1 = every note got change |

## Verification
Saturation of the 10-note count is the hardest condition to reach. It can only be seen through 20-unit notes, and they also drain the 5-note count. The stimulus first feeds 300 alternating 5/10 pairs, which pushes the 10 count past its limit and leaves no 5-notes. It then adds 255 fives and pays with 255 twenties, and every one of them must pass only if the 10 count stopped at 255. A final twenty must then fail. Pair-first priority is exposed by 5,5,5,5,10,20,10,10: this sequence passes only if the twenty took the 10+5 pair rather than three fives.

// File: rtl/change_pkg.sv
package change_pkg;
  localparam int CNT_W = 8;

  typedef enum logic [1:0] {
    NOTE_SKIP = 2'b00,
    NOTE_5    = 2'b01,
    NOTE_10   = 2'b10,
    NOTE_20   = 2'b11
  } note_e;

  typedef enum logic {
    ST_OPEN  = 1'b0,
    ST_SHORT = 1'b1
  } ledger_st_e;
endpackage

// File: rtl/note_decoder.sv
module note_decoder
  import change_pkg::*;
(
  input  logic       valid_i,
  input  logic [1:0] code_i,
  output logic       is5_o,
  output logic       is10_o,
  output logic       is20_o
);
  note_e code;
  assign code = note_e'(code_i);

  always_comb begin
    is5_o  = 1'b0;
    is10_o = 1'b0;
    is20_o = 1'b0;
    if (valid_i) begin
      unique case (code)
        NOTE_5:  is5_o  = 1'b1;
        NOTE_10: is10_o = 1'b1;
        NOTE_20: is20_o = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/change_policy.sv
module change_policy #(
  parameter int W = 8
) (
  input  logic         is5_i,
  input  logic         is10_i,
  input  logic         is20_i,
  input  logic [W-1:0] fives_i,
  input  logic [W-1:0] tens_i,
  output logic         short_o,
  output logic         inc5_o,
  output logic [1:0]   dec5_o,
  output logic         inc10_o,
  output logic         dec10_o
);
  localparam logic [W-1:0] THREE = W'(3);

  logic has5, has10, pair_ok, triple_ok;
  assign has5      = (fives_i != '0);
  assign has10     = (tens_i != '0);
  assign pair_ok   = has5 && has10;
  assign triple_ok = (fives_i >= THREE);

  always_comb begin
    short_o = 1'b0;
    inc5_o  = 1'b0;
    dec5_o  = 2'd0;
    inc10_o = 1'b0;
    dec10_o = 1'b0;
    if (is5_i) begin
      inc5_o = 1'b1;
    end else if (is10_i) begin
      if (has5) begin
        dec5_o  = 2'd1;
        inc10_o = 1'b1;
      end else begin
        short_o = 1'b1;
      end
    end else if (is20_i) begin
      if (pair_ok) begin
        dec5_o  = 2'd1;
        dec10_o = 1'b1;
      end else if (triple_ok) begin
        dec5_o  = 2'd3;
      end else begin
        short_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         zero_i,
  input  logic         inc_i,
  input  logic [1:0]   dec_i,
  output logic [W-1:0] count_o
);
  localparam int SW = W + 1;
  localparam logic [W-1:0] MAX = '1;

  logic [W-1:0]  count_q;
  logic [SW-1:0] sum;
  logic [W-1:0]  next;

  always_comb begin
    sum  = {1'b0, count_q} + SW'(inc_i) - SW'(dec_i);
    next = (sum > {1'b0, MAX}) ? MAX : sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (zero_i) count_q <= '0;
    else             count_q <= next;
  end

  assign count_o = count_q;

  // R3 / R5: the policy never takes more notes than are held
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_i |-> ({{(W-2){1'b0}}, dec_i} <= count_q));

  // R9: at the top, a lone increment leaves the count at its maximum
  assert_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero_i && inc_i && dec_i == 2'd0 && count_q == MAX) |=> (count_q == MAX));
endmodule

// File: rtl/change_ledger.sv
module change_ledger
  import change_pkg::*;
#(
  parameter int CNT_W = change_pkg::CNT_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear_i,
  input  logic       note_valid_i,
  input  logic [1:0] note_code_i,
  output logic       note_ready_o,
  input  logic       seq_end_i,
  output logic       done_o,
  output logic       ok_o
);
  logic is5, is10, is20;
  logic short_n, inc5, inc10, dec10;
  logic [1:0] dec5;
  logic [CNT_W-1:0] fives, tens;
  ledger_st_e st_q;
  logic live, commit, short_now, done_q, ok_q;

  assign note_ready_o = 1'b1;

  note_decoder u_dec (
    .valid_i (note_valid_i & note_ready_o),
    .code_i  (note_code_i),
    .is5_o   (is5),
    .is10_o  (is10),
    .is20_o  (is20)
  );

  change_policy #(.W(CNT_W)) u_policy (
    .is5_i   (is5),
    .is10_i  (is10),
    .is20_i  (is20),
    .fives_i (fives),
    .tens_i  (tens),
    .short_o (short_n),
    .inc5_o  (inc5),
    .dec5_o  (dec5),
    .inc10_o (inc10),
    .dec10_o (dec10)
  );

  assign live      = (st_q == ST_OPEN) && !clear_i;
  assign commit    = live && !short_n;
  assign short_now = live && short_n;

  sat_counter #(.W(CNT_W)) u_fives (
    .clk     (clk),
    .rst_n   (rst_n),
    .zero_i  (clear_i),
    .inc_i   (commit & inc5),
    .dec_i   (commit ? dec5 : 2'd0),
    .count_o (fives)
  );

  sat_counter #(.W(CNT_W)) u_tens (
    .clk     (clk),
    .rst_n   (rst_n),
    .zero_i  (clear_i),
    .inc_i   (commit & inc10),
    .dec_i   ({1'b0, commit & dec10}),
    .count_o (tens)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         st_q <= ST_OPEN;
    else if (clear_i)   st_q <= ST_OPEN;
    else if (short_now) st_q <= ST_SHORT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      done_q <= seq_end_i && !clear_i;
      if (seq_end_i && !clear_i)
        ok_q <= (st_q == ST_OPEN) && !short_now;
    end
  end

  assign done_o = done_q;
  assign ok_o   = ok_q;

  assert_ready_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    note_ready_o);

  assert_ten_needs_five_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (live && is10 && fives == '0) |=> (st_q == ST_SHORT));

  assert_pair_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (live && is20 && fives != '0 && tens != '0) |=> (tens == $past(tens) - 1'b1));

  assert_skip_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !is5 && !is10 && !is20) |=> ($stable(fives) && $stable(tens)));

  assert_sticky_short_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SHORT && !clear_i) |=> (st_q == ST_SHORT && $stable(fives) && $stable(tens)));

  assert_done_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_end_i && !clear_i) |=> done_o);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_end_i && !clear_i) |=> !done_o);

  assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (fives == '0 && tens == '0 && st_q == ST_OPEN));
endmodule

// File: tb/change_ledger_bench.sv
module change_ledger_bench;
  localparam logic [1:0] N5 = 2'b01, N10 = 2'b10, N20 = 2'b11, NX = 2'b00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear_i = 1'b0;
  logic note_valid_i = 1'b0;
  logic [1:0] note_code_i = 2'b00;
  logic seq_end_i = 1'b0;
  logic note_ready_o, done_o, ok_o;

  int checks = 0;
  int errors = 0;
  bit exp_q[$];
  string tag_q[$];
  logic [1:0] notes[$];

  always #4 clk = ~clk;

  change_ledger u_change_ledger (
    .clk, .rst_n, .clear_i, .note_valid_i, .note_code_i,
    .note_ready_o, .seq_end_i, .done_o, .ok_o
  );

  task automatic check(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops one expected verdict per done pulse
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected done pulse", 1, 0);
      end else begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(ok_o == e, t, int'(ok_o), int'(e));
      end
    end
  end

  task automatic do_clear();
    @(negedge clk); clear_i = 1'b1;
    @(negedge clk); clear_i = 1'b0;
  endtask

  task automatic send_notes();
    foreach (notes[i]) begin
      @(negedge clk);
      note_valid_i = 1'b1;
      note_code_i  = notes[i];
    end
    @(negedge clk);
    note_valid_i = 1'b0;
    note_code_i  = NX;
  endtask

  task automatic finish_seq(input bit exp_ok, input string tag);
    exp_q.push_back(exp_ok);
    tag_q.push_back(tag);
    seq_end_i = 1'b1;
    @(negedge clk);
    seq_end_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_seq(input bit exp_ok, input string tag);
    do_clear();
    send_notes();
    finish_seq(exp_ok, tag);
    notes.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(done_o == 1'b0, "R1 reset done", int'(done_o), 0);
    check(ok_o == 1'b0, "R1 reset ok", int'(ok_o), 0);
    check(note_ready_o == 1'b1, "R1 ready high", int'(note_ready_o), 1);

    notes = '{N10};                          run_seq(1'b0, "R1 ten first fails");
    notes = '{N5, N5, N5};                   run_seq(1'b1, "R2 fives only pass");
    notes = '{N5, N10};                      run_seq(1'b1, "R3 ten with five pass");
    notes = '{N5, N10, N10};                 run_seq(1'b0, "R3 second ten short");
    notes = '{N5, N5, N5, N10, N20};         run_seq(1'b1, "R8 example pass");
    notes = '{N5, N5, N10, N10, N20};        run_seq(1'b0, "R8 example fail");
    notes = '{N5, N5, N5, N10, N5, N5, N10, N20, N20, N20};
                                             run_seq(1'b0, "R8 ten-note fail");
    notes = '{N5, N5, N5, N5, N10, N20, N10, N10};
                                             run_seq(1'b1, "R4 pair taken first");
    notes = '{N5, N5, N5, N20};              run_seq(1'b1, "R5 three fives pass");
    notes = '{N5, N5, N20};                  run_seq(1'b0, "R5 two fives short");
    notes = '{NX, N10};                      run_seq(1'b0, "R6 skip adds no five");
    notes = '{N5, NX, NX, N10, N10};         run_seq(1'b0, "R6 skip between");
    notes = '{N5, NX, N10};                  run_seq(1'b1, "R6 skip keeps five");
    notes = '{N10, N5, N5, N5};              run_seq(1'b0, "R7 sticky after short");
    notes = '{N10, N5, N10};                 run_seq(1'b0, "R7 notes ignored");

    // R8: note in same cycle as end strobe counts
    do_clear();
    notes = '{N5, N5};
    send_notes();
    notes.delete();
    note_valid_i = 1'b1; note_code_i = N20;
    finish_seq(1'b0, "R8 same-cycle twenty short");
    note_valid_i = 1'b0;
    do_clear();
    note_valid_i = 1'b1; note_code_i = N5;
    finish_seq(1'b1, "R8 same-cycle five pass");
    note_valid_i = 1'b0;

    // R8: verdict held between requests
    repeat (3) @(negedge clk);
    check(ok_o == 1'b1 && done_o == 1'b0, "R8 ok held", int'(ok_o), 1);

    // R10: clear beats a simultaneous note
    @(negedge clk);
    clear_i = 1'b1; note_valid_i = 1'b1; note_code_i = N5;
    @(negedge clk);
    clear_i = 1'b0; note_code_i = N10;
    @(negedge clk);
    note_valid_i = 1'b0;
    finish_seq(1'b0, "R10 clear drops note");
    // R10: clear beats a simultaneous end strobe
    @(negedge clk);
    clear_i = 1'b1; seq_end_i = 1'b1;
    @(negedge clk);
    clear_i = 1'b0; seq_end_i = 1'b0;
    check(done_o == 1'b0, "R10 end dropped", int'(done_o), 0);

    // R9: five count saturates at 255
    do_clear();
    for (int i = 0; i < 300; i++) notes.push_back(N5);
    for (int i = 0; i < 255; i++) notes.push_back(N10);
    run_seq(1'b1, "R9 fives at max pass");
    for (int i = 0; i < 300; i++) notes.push_back(N5);
    for (int i = 0; i < 256; i++) notes.push_back(N10);
    run_seq(1'b0, "R9 fives saturated not wrapped");

    // R9: ten count saturates at 255
    for (int i = 0; i < 300; i++) begin notes.push_back(N5); notes.push_back(N10); end
    for (int i = 0; i < 255; i++) notes.push_back(N5);
    for (int i = 0; i < 255; i++) notes.push_back(N20);
    run_seq(1'b1, "R9 tens at max pass");
    for (int i = 0; i < 300; i++) begin notes.push_back(N5); notes.push_back(N10); end
    for (int i = 0; i < 255; i++) notes.push_back(N5);
    for (int i = 0; i < 256; i++) notes.push_back(N20);
    run_seq(1'b0, "R9 tens drained");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R8 all verdicts seen", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule